// File: doc/BRIEF.md
# Clock Source Selector with Fail-Safe Fallback

This block decides which of four oscillators drives the system clock. The four candidates are an external primary group (whose variant, such as a crystal with PLL or a direct external clock, is named by a 4-bit mode field), a fast internal RC, a slow low-power internal RC and a secondary low-power oscillator. Every candidate is identified by a 2-bit code that the selector uses for reset choice, switch requests and status alike: 2'b11 primary, 2'b10 slow RC, 2'b01 fast RC, 2'b00 secondary oscillator.

While reset is held the block takes its starting source, the primary mode and a single switching-permission bit from configuration inputs. After reset, software may ask for another source through a small write port. If permission is granted, a missing-clock monitor counts reference cycles since the last edge of the active source. A dead source forces a move to the fast RC and raises a sticky flag. Every move parks the output enables low on the old source, waits for the target to be valid, changes the select, and only then re-enables, so no shortened pulse can reach the clock tree.

The block runs on a reference clock. The oscillator valid lines and edge pulses are assumed to be already synchronised to it.

Top module: `clk_source_sel`

## Requirements
- R1: While `rst_n` is low the active source is loaded from `cfg_src`. After reset `cur_src` equals that code and `src_en` has only bit number `cfg_src` set (bit 0 secondary, bit 1 fast RC, bit 2 slow RC, bit 3 primary).
- R2: `cfg_pmode` is captured at reset whatever source is chosen. `prim_mode` shows the captured value whenever `cur_src` is 2'b11 and reads 0 otherwise, including after a later switch into the primary source.
- R3: With `cfg_switch_en` low at reset, neither a software request nor a missing clock ever changes `cur_src`, `src_en`, `sw_pending` or `fail_flag`.
- R4: A write with `reg_go` set that is accepted raises `sw_pending` and drives `src_en` to zero after the same edge. Once the target is valid, `cur_src` takes the new code one edge later while still parked. One edge after that `src_en` selects the new source and `sw_pending` clears by itself.
- R5: If the target stops being valid after acceptance, the outputs stay parked with `cur_src` unchanged until it is valid again.
- R6: A request naming the active source, or a source whose `osc_valid` bit is low, is ignored: `sw_pending`, `src_en` and `cur_src` keep their values.
- R7: The monitor counts reference cycles since the last `osc_edge` pulse of the active source. A failure is declared after `fs_limit` cycles with no such pulse, and the fallback is taken on the following edge.
- R8: A failure always switches to the fast RC (code 2'b01) and sets `fail_flag`. The flag stays set until a write with `reg_fail_clr`.
- R9: If a failure and an accepted-looking software request fall on the same edge, the failure wins: the target is the fast RC and `sw_pending` stays low.
- R10: `src_en` never has more than one bit set, and `cur_src` only changes while `mux_parked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all control logic |
| rst_n | input | 1 | Synchronous active-low reset (power-on or brown-out) |
| cfg_src | input | 2 | Configured reset source code |
| cfg_pmode | input | 4 | Configured primary variant |
| cfg_switch_en | input | 1 | Configured permission for switching and fail-safe |
| fs_limit | input | CNT_W | Missing-clock timeout in reference cycles |
| osc_valid | input | 4 | Per-source valid indication, indexed by code |
| osc_edge | input | 4 | Per-source edge pulse, indexed by code |
| reg_wr | input | 1 | Control register write strobe |
| reg_new_src | input | 2 | Requested source code |
| reg_go | input | 1 | Switch-request bit of the write |
| reg_fail_clr | input | 1 | Clears the sticky failure flag |
| src_en | output | 4 | One-hot gate enable per source, all zero when parked |
| mux_parked | output | 1 | High while the output is held low during a switch |
| cur_src | output | 2 | Code of the active source |
| sw_pending | output | 1 | Software switch in progress, clears on completion |
| fail_flag | output | 1 | Sticky fail-safe event flag |
| prim_mode | output | 4 | Active primary variant, zero when not on primary |

## Verification
Fail-safe detection and a software switch request can land on the same reference edge, and the block must then honour only the failure. The bench stops the free-running edge pulses and gives one pulse on the primary source on a known cycle. It counts the timeout to find the edge on which the failure fires and places a valid software write to the slow RC on exactly that edge. It then checks that the flag rises, that no software switch is pending, and that the fast RC ends up active.

// File: rtl/clksel_pkg.sv
// Package: shared codes and state encoding for the clock source selector.
// Assumes four sources addressed by a 2-bit code.
package clksel_pkg;
    localparam int NUM_SRC = 4;
    localparam int CODE_W  = $clog2(NUM_SRC);

    localparam logic [CODE_W-1:0] SRC_LOWOSC  = 2'b00;
    localparam logic [CODE_W-1:0] SRC_FASTRC  = 2'b01;
    localparam logic [CODE_W-1:0] SRC_SLOWRC  = 2'b10;
    localparam logic [CODE_W-1:0] SRC_PRIMARY = 2'b11;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_PARK    = 2'b01,
        ST_RELEASE = 2'b10
    } sw_state_t;
endpackage

// File: rtl/clksel_miss_det.sv
// Missing-clock detector: counts reference cycles since the last edge pulse
// of the monitored source and flags it dead once the limit is reached.
// Assumes edge_seen is already synchronised to clk; held idle when disabled.
module clksel_miss_det #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             edge_seen,
    input  logic [CNT_W-1:0] limit,
    output logic             dead
);
    logic [CNT_W-1:0] gap_cnt;

    // Cycle counter since last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || edge_seen) begin
            gap_cnt <= '0;
        end else if (gap_cnt != limit) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Dead when the window has elapsed without an edge.
    always_comb begin
        dead = enable && !edge_seen && (gap_cnt == limit);
    end
endmodule

// File: rtl/clksel_ctrl.sv
// Switch controller: loads the reset configuration, accepts software and
// fail-safe requests and sequences park, select and release.
// Assumes osc_valid is synchronised; failure takes priority over software.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int PM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_src,
    input  logic [PM_W-1:0]   cfg_pmode,
    input  logic              cfg_switch_en,
    input  logic [NUM_SRC-1:0] osc_valid,
    input  logic              dead,
    input  logic              reg_wr,
    input  logic [CODE_W-1:0] reg_new_src,
    input  logic              reg_go,
    input  logic              reg_fail_clr,
    output logic [CODE_W-1:0] cur_src,
    output logic              gate_on,
    output logic              mon_enable,
    output logic              sw_en_q,
    output logic              sw_pending,
    output logic              fail_flag,
    output logic [PM_W-1:0]   prim_mode
);
    sw_state_t         state;
    logic [CODE_W-1:0] tgt_src;
    logic [PM_W-1:0]   pmode_q;
    logic              fail_go;
    logic              sw_go;

    // Request qualification: failure first, software only if still free.
    always_comb begin
        mon_enable = sw_en_q && (state == ST_RUN);
        fail_go    = dead && (cur_src != SRC_FASTRC);
        sw_go      = sw_en_q && (state == ST_RUN) && reg_wr && reg_go &&
                     (reg_new_src != cur_src) && osc_valid[reg_new_src] &&
                     !fail_go;
    end

    // Configuration capture, switch sequencing and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmode_q    <= cfg_pmode;
            sw_en_q    <= cfg_switch_en;
            cur_src    <= cfg_src;
            tgt_src    <= cfg_src;
            gate_on    <= 1'b1;
            state      <= ST_RUN;
            sw_pending <= 1'b0;
            fail_flag  <= 1'b0;
        end else begin
            if (reg_wr && reg_fail_clr) begin
                fail_flag <= 1'b0;
            end
            case (state)
                ST_RUN: begin
                    if (fail_go) begin
                        tgt_src   <= SRC_FASTRC;
                        gate_on   <= 1'b0;
                        fail_flag <= 1'b1;
                        state     <= ST_PARK;
                    end else if (sw_go) begin
                        tgt_src    <= reg_new_src;
                        gate_on    <= 1'b0;
                        sw_pending <= 1'b1;
                        state      <= ST_PARK;
                    end
                end
                ST_PARK: begin
                    if (osc_valid[tgt_src]) begin
                        cur_src <= tgt_src;
                        state   <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    gate_on    <= 1'b1;
                    sw_pending <= 1'b0;
                    state      <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Active primary variant is shown only while on the primary source.
    always_comb begin
        prim_mode = (cur_src == SRC_PRIMARY) ? pmode_q : '0;
    end
endmodule

// File: rtl/clksel_gate.sv
// Output gate: turns the select code into one-hot enables, all low while
// parked. Assumes the select only moves while the gate is off.
module clksel_gate
    import clksel_pkg::*;
(
    input  logic [CODE_W-1:0]  sel,
    input  logic               gate_on,
    output logic [NUM_SRC-1:0] src_en
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        // One enable per source.
        always_comb begin
            src_en[i] = gate_on && (sel == CODE_W'(i));
        end
    end
endmodule

// File: rtl/clk_source_sel.sv
// Top: clock source selector with software switching and fail-safe
// fallback. Assumes all inputs are synchronous to the reference clock.
module clk_source_sel
    import clksel_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PM_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  cfg_src,
    input  logic [PM_W-1:0]    cfg_pmode,
    input  logic               cfg_switch_en,
    input  logic [CNT_W-1:0]   fs_limit,
    input  logic [NUM_SRC-1:0] osc_valid,
    input  logic [NUM_SRC-1:0] osc_edge,
    input  logic               reg_wr,
    input  logic [CODE_W-1:0]  reg_new_src,
    input  logic               reg_go,
    input  logic               reg_fail_clr,
    output logic [NUM_SRC-1:0] src_en,
    output logic               mux_parked,
    output logic [CODE_W-1:0]  cur_src,
    output logic               sw_pending,
    output logic               fail_flag,
    output logic [PM_W-1:0]    prim_mode
);
    logic gate_on;
    logic mon_enable;
    logic dead;
    logic sw_en_q;
    logic mon_edge;

    // Edge pulse of the currently active source feeds the monitor.
    always_comb begin
        mon_edge   = osc_edge[cur_src];
        mux_parked = !gate_on;
    end

    clksel_miss_det #(.CNT_W(CNT_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mon_enable),
        .edge_seen (mon_edge),
        .limit     (fs_limit),
        .dead      (dead)
    );

    clksel_ctrl #(.PM_W(PM_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_src       (cfg_src),
        .cfg_pmode     (cfg_pmode),
        .cfg_switch_en (cfg_switch_en),
        .osc_valid     (osc_valid),
        .dead          (dead),
        .reg_wr        (reg_wr),
        .reg_new_src   (reg_new_src),
        .reg_go        (reg_go),
        .reg_fail_clr  (reg_fail_clr),
        .cur_src       (cur_src),
        .gate_on       (gate_on),
        .mon_enable    (mon_enable),
        .sw_en_q       (sw_en_q),
        .sw_pending    (sw_pending),
        .fail_flag     (fail_flag),
        .prim_mode     (prim_mode)
    );

    clksel_gate u_gate (
        .sel     (cur_src),
        .gate_on (gate_on),
        .src_en  (src_en)
    );
endmodule

// File: rtl/clksel_checker.sv
// Checker: temporal properties of the selector, bound to the top module.
module clksel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_en_q,
    input logic [3:0] src_en,
    input logic [1:0] cur_src,
    input logic       mux_parked,
    input logic       sw_pending,
    input logic       fail_flag
);
    p_onehot_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_en));

    p_en_matches_cur_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en != 4'b0) |-> (src_en == (4'b1 << cur_src)));

    p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en_q |=> ($stable(cur_src) && !sw_pending && !fail_flag));

    p_change_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> mux_parked);

    p_fail_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag) |-> mux_parked);

    p_done_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_pending) |-> !mux_parked);
endmodule

bind clk_source_sel clksel_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_en_q    (sw_en_q),
    .src_en     (src_en),
    .cur_src    (cur_src),
    .mux_parked (mux_parked),
    .sw_pending (sw_pending),
    .fail_flag  (fail_flag)
);

// File: tb/clk_source_sel_tb.sv
module clk_source_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_src = 2'b11;
    logic [3:0] cfg_pmode = 4'h0;
    logic       cfg_switch_en = 1'b1;
    logic [7:0] fs_limit = 8'd8;
    logic [3:0] osc_valid = 4'hF;
    logic [3:0] osc_edge = 4'h0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_new_src = 2'b00;
    logic       reg_go = 1'b0;
    logic       reg_fail_clr = 1'b0;
    logic [3:0] src_en;
    logic       mux_parked;
    logic [1:0] cur_src;
    logic       sw_pending;
    logic       fail_flag;
    logic [3:0] prim_mode;

    int checks = 0;
    int fails  = 0;
    logic       auto_tick = 1'b1;
    logic       phase = 1'b0;
    logic [3:0] edge_mask = 4'hF;

    always #10 clk = ~clk;

    clk_source_sel u_dut (.*);

    // Free-running edge pulses, every other cycle, on the enabled sources.
    always @(negedge clk) begin
        if (auto_tick) begin
            osc_edge <= phase ? edge_mask : 4'h0;
            phase    <= ~phase;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] src, input logic [3:0] pm, input logic en);
        @(negedge clk);
        auto_tick = 1'b1; edge_mask = 4'hF; osc_valid = 4'hF;
        cfg_src = src; cfg_pmode = pm; cfg_switch_en = en;
        reg_wr = 0; reg_go = 0; reg_fail_clr = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic write_req(input logic [1:0] src, input logic go, input logic clr);
        reg_wr = 1; reg_new_src = src; reg_go = go; reg_fail_clr = clr;
        @(negedge clk);
        reg_wr = 0; reg_go = 0; reg_fail_clr = 0;
    endtask

    task automatic t_reset_sources();
        for (int c = 0; c < 4; c++) begin
            do_reset(2'(c), 4'h5, 1'b1);
            chk("R1 cur_src after reset", 32'(cur_src), 32'(c));
            chk("R1 src_en after reset", 32'(src_en), 32'(4'b1 << c));
            chk("R2 prim_mode at reset", 32'(prim_mode), (c == 3) ? 32'h5 : 32'h0);
        end
    endtask

    task automatic t_switch_primary();
        do_reset(2'b01, 4'hA, 1'b1);
        write_req(2'b11, 1'b1, 1'b0);
        chk("R4 parked after accept", 32'(src_en), 32'h0);
        chk("R4 pending after accept", 32'(sw_pending), 32'h1);
        @(negedge clk);
        chk("R4 cur updated while parked", 32'(cur_src), 32'h3);
        chk("R4 still parked", 32'(mux_parked), 32'h1);
        @(negedge clk);
        chk("R4 new enable", 32'(src_en), 32'h8);
        chk("R4 pending cleared", 32'(sw_pending), 32'h0);
        chk("R2 kept primary mode used", 32'(prim_mode), 32'hA);
    endtask

    task automatic t_target_drops();
        do_reset(2'b11, 4'h3, 1'b1);
        write_req(2'b10, 1'b1, 1'b0);
        osc_valid = 4'b1011;
        repeat (3) @(negedge clk);
        chk("R5 parked while invalid", 32'(src_en), 32'h0);
        chk("R5 cur held while invalid", 32'(cur_src), 32'h3);
        osc_valid = 4'hF;
        repeat (2) @(negedge clk);
        chk("R5 completes when valid", 32'(src_en), 32'h4);
        chk("R2 prim_mode off primary", 32'(prim_mode), 32'h0);
    endtask

    task automatic t_ignored();
        do_reset(2'b10, 4'h0, 1'b1);
        write_req(2'b10, 1'b1, 1'b0);
        chk("R6 same source no pending", 32'(sw_pending), 32'h0);
        chk("R6 same source enable kept", 32'(src_en), 32'h4);
        osc_valid = 4'b1110;
        write_req(2'b00, 1'b1, 1'b0);
        chk("R6 invalid target no pending", 32'(sw_pending), 32'h0);
        @(negedge clk);
        chk("R6 invalid target cur kept", 32'(cur_src), 32'h2);
        chk("R6 invalid target enable kept", 32'(src_en), 32'h4);
        osc_valid = 4'hF;
    endtask

    task automatic t_locked();
        do_reset(2'b11, 4'h0, 1'b0);
        write_req(2'b01, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 locked no switch", 32'(cur_src), 32'h3);
        edge_mask = 4'h0;
        repeat (40) @(negedge clk);
        chk("R3 locked no fail", 32'(fail_flag), 32'h0);
        chk("R3 locked enable kept", 32'(src_en), 32'h8);
    endtask

    task automatic t_failsafe();
        do_reset(2'b11, 4'h0, 1'b1);
        edge_mask = 4'b0111;
        repeat (5) @(negedge clk);
        chk("R7 no fail before timeout", 32'(fail_flag), 32'h0);
        repeat (16) @(negedge clk);
        chk("R8 fail flag set", 32'(fail_flag), 32'h1);
        chk("R8 fallback to fast RC", 32'(cur_src), 32'h1);
        chk("R8 fast RC enabled", 32'(src_en), 32'h2);
        repeat (3) @(negedge clk);
        chk("R8 flag sticky", 32'(fail_flag), 32'h1);
        write_req(2'b00, 1'b0, 1'b1);
        chk("R8 flag cleared by write", 32'(fail_flag), 32'h0);
    endtask

    task automatic t_collision();
        do_reset(2'b11, 4'h0, 1'b1);
        auto_tick = 1'b0;
        @(negedge clk);
        osc_edge = 4'b1000;
        @(negedge clk);
        osc_edge = 4'h0;
        repeat (8) @(negedge clk);
        chk("R7 no fail at exact limit", 32'(fail_flag), 32'h0);
        chk("R7 not parked at exact limit", 32'(mux_parked), 32'h0);
        write_req(2'b10, 1'b1, 1'b0);
        chk("R9 fail wins flag", 32'(fail_flag), 32'h1);
        chk("R9 software dropped", 32'(sw_pending), 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 target is fast RC", 32'(cur_src), 32'h1);
        chk("R9 fast RC enabled", 32'(src_en), 32'h2);
        auto_tick = 1'b1;
    endtask

    initial begin
        t_reset_sources();
        t_switch_primary();
        t_target_drops();
        t_ignored();
        t_locked();
        t_failsafe();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule